// File: doc/BRIEF.md
# Binary and Packed-Decimal Adder-Subtractor with Status Flags

This block performs add-with-carry and subtract-with-borrow on two operands, either as plain binary or as packed BCD with automatic digit correction. It owns a six-bit status register holding carry, zero, overflow and negative result flags, plus two mode flags: a decimal-mode flag and a narrow-width flag. The narrow-width flag selects 8-bit operation (two BCD digits) or 16-bit operation (four BCD digits).

The arithmetic always uses the current mode flags and the current carry. Subtraction treats the carry as an inverted borrow, so a carry of 1 means no borrow is pending. The mode flags and result flags are changed only through the same operation port. Mask operations set or clear any chosen group of status bits, and two dedicated operations set or clear the carry alone.

Operations are presented one per clock with a valid strobe. The result register and the status register update on the clock edge that accepts the operation, and the new values appear on the outputs in the following cycle.

Top module: `bcd_alu_core`

## Requirements
- R1: Op code 1 (add with carry), in binary mode, computes opa + opb + C at the active width (16 bits when flag bit 5 is 0, 8 bits when it is 1). C becomes the carry out of that width.
- R2: Op code 2 (subtract with borrow), in binary mode, computes opa - opb - (1 - C) at the active width. C becomes 1 when no borrow occurred and 0 when one did.
- R3: With the decimal flag (bit 4) set, op code 1 adds the operands as packed BCD with C as carry in, over four digits (16-bit) or two digits (8-bit). Each digit above 9 is corrected by adding 6 and carrying into the next digit, and C becomes the decimal carry out.
- R4: With the decimal flag set, op code 2 subtracts as packed BCD with borrow (1 - C). The result is the ten's complement modulo 10^digits, and C becomes 1 exactly when no decimal borrow occurred.
- R5: In 8-bit mode, the upper byte of an arithmetic result equals the upper byte of opa.
- R6: After an arithmetic operation, Z (bit 1) is 1 exactly when the result at the active width is zero.
- R7: After an arithmetic operation, N (bit 3) equals the result's top bit at the active width (bit 7 or bit 15).
- R8: After a binary arithmetic operation, V (bit 2) reports signed two's-complement overflow at the active width. After a decimal one, V is 0.
- R9: Op code 3 sets every status bit whose mask bit is 1, and op code 4 clears every such bit. Other status bits and the result are unchanged. The status bits are C=0, Z=1, V=2, N=3, decimal=4, narrow=5.
- R10: Op code 5 sets C and op code 6 clears C. All other status bits and the result are unchanged.
- R11: When valid is low, or the op code is 0, the result and the status register hold their values.
- R12: Synchronous reset clears the result and all status bits, which selects binary 16-bit mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation strobe |
| op_code_i | input | 3 | Operation code (0 none, 1 add, 2 subtract, 3 set mask, 4 clear mask, 5 set carry, 6 clear carry) |
| opa_i | input | 16 | First operand |
| opb_i | input | 16 | Second operand |
| mask_i | input | 6 | Status-bit mask for op codes 3 and 4 |
| result_o | output | 16 | Registered result |
| flags_o | output | 6 | Status register {narrow, decimal, N, V, Z, C} |

## Verification
The bench builds the block with its default parameters: a 16-bit word, an 8-bit narrow width and 4-bit digits. This means both the four-digit and the two-digit decimal chains are exercised, as well as the carry taps at bit 8 and bit 16. The random stream mixes mask operations that flip the decimal and narrow flags between arithmetic steps, so all four mode combinations are reached with carry both set and clear. Directed cases cover the points where digit correction and width selection interact: 9999+1, 0-1 in decimal, and a narrow add whose carry must not disturb the upper byte.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int DIGIT_W = 4;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_ADC  = 3'd1,
        OP_SBC  = 3'd2,
        OP_SETM = 3'd3,
        OP_CLRM = 3'd4,
        OP_SETC = 3'd5,
        OP_CLRC = 3'd6
    } op_e;

    typedef struct packed {
        logic w;   // narrow (8-bit) mode
        logic d;   // decimal mode
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);
    localparam int F_C = 0;
    localparam int F_Z = 1;
    localparam int F_V = 2;
    localparam int F_N = 3;
    localparam int F_D = 4;
    localparam int F_W = 5;

    function automatic logic is_arith(input op_e op);
        return (op == OP_ADC) || (op == OP_SBC);
    endfunction

endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
    import alu_pkg::*;
(
    input  logic [DIGIT_W-1:0] a_i,
    input  logic [DIGIT_W-1:0] b_i,
    input  logic               cin_i,   // carry (add) or borrow (sub)
    input  logic               sub_i,
    output logic [DIGIT_W-1:0] d_o,
    output logic               cout_o
);
    logic [DIGIT_W:0] raw;

    always_comb begin
        if (!sub_i) begin
            raw = {1'b0, a_i} + {1'b0, b_i} + {{DIGIT_W{1'b0}}, cin_i};
            if (raw > 5'd9) begin
                d_o    = raw[DIGIT_W-1:0] + 4'd6;
                cout_o = 1'b1;
            end else begin
                d_o    = raw[DIGIT_W-1:0];
                cout_o = 1'b0;
            end
        end else begin
            raw = {1'b0, a_i} - {1'b0, b_i} - {{DIGIT_W{1'b0}}, cin_i};
            if (raw[DIGIT_W]) begin
                d_o    = raw[DIGIT_W-1:0] - 4'd6;
                cout_o = 1'b1;
            end else begin
                d_o    = raw[DIGIT_W-1:0];
                cout_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/bcd_chain.sv
module bcd_chain
    import alu_pkg::*;
#(
    parameter int DIGITS        = WORD_W / DIGIT_W,
    parameter int NARROW_DIGITS = BYTE_W / DIGIT_W
) (
    input  logic [DIGITS*DIGIT_W-1:0] a_i,
    input  logic [DIGITS*DIGIT_W-1:0] b_i,
    input  logic                      carry_flag_i,
    input  logic                      sub_i,
    input  logic                      narrow_i,
    output logic [DIGITS*DIGIT_W-1:0] sum_o,
    output logic                      carry_flag_o
);
    logic [DIGITS:0] link;
    logic            tap;

    assign link[0] = sub_i ? ~carry_flag_i : carry_flag_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        bcd_digit_cell cell_i (
            .a_i    (a_i[g*DIGIT_W +: DIGIT_W]),
            .b_i    (b_i[g*DIGIT_W +: DIGIT_W]),
            .cin_i  (link[g]),
            .sub_i  (sub_i),
            .d_o    (sum_o[g*DIGIT_W +: DIGIT_W]),
            .cout_o (link[g+1])
        );
    end

    assign tap          = narrow_i ? link[NARROW_DIGITS] : link[DIGITS];
    assign carry_flag_o = sub_i ? ~tap : tap;
endmodule

// File: rtl/bin_addsub.sv
module bin_addsub #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              carry_flag_i,
    input  logic              sub_i,
    input  logic              narrow_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              carry_flag_o,
    output logic              ovf_o
);
    logic [DATA_W-1:0]   bx;
    logic [DATA_W:0]     full;
    logic [NARROW_W:0]   low;
    logic                ovf_wide, ovf_narrow;

    always_comb begin
        bx   = sub_i ? ~b_i : b_i;
        full = {1'b0, a_i} + {1'b0, bx} + {{DATA_W{1'b0}}, carry_flag_i};
        low  = {1'b0, a_i[NARROW_W-1:0]} + {1'b0, bx[NARROW_W-1:0]}
             + {{NARROW_W{1'b0}}, carry_flag_i};
        ovf_wide   = (a_i[DATA_W-1] == bx[DATA_W-1]) &&
                     (full[DATA_W-1] != a_i[DATA_W-1]);
        ovf_narrow = (a_i[NARROW_W-1] == bx[NARROW_W-1]) &&
                     (low[NARROW_W-1] != a_i[NARROW_W-1]);
        sum_o        = full[DATA_W-1:0];
        carry_flag_o = narrow_i ? low[NARROW_W] : full[DATA_W];
        ovf_o        = narrow_i ? ovf_narrow : ovf_wide;
    end
endmodule

// File: rtl/flag_unit.sv
module flag_unit
    import alu_pkg::*;
(
    input  logic              valid_i,
    input  op_e               op_i,
    input  logic [FLAG_W-1:0] mask_i,
    input  flags_t            cur_i,
    input  logic              carry_i,
    input  logic              zero_i,
    input  logic              neg_i,
    input  logic              ovf_i,
    output flags_t            nxt_o
);
    always_comb begin
        nxt_o = cur_i;
        if (valid_i) begin
            unique case (op_i)
                OP_ADC, OP_SBC: begin
                    nxt_o.c = carry_i;
                    nxt_o.z = zero_i;
                    nxt_o.n = neg_i;
                    nxt_o.v = ovf_i;
                end
                OP_SETM: nxt_o = flags_t'(cur_i | mask_i);
                OP_CLRM: nxt_o = flags_t'(cur_i & ~mask_i);
                OP_SETC: nxt_o.c = 1'b1;
                OP_CLRC: nxt_o.c = 1'b0;
                default: nxt_o = cur_i;
            endcase
        end
    end
endmodule

// File: rtl/bcd_alu_core.sv
module bcd_alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W   = WORD_W,
    parameter int NARROW_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid_i,
    input  logic [2:0]        op_code_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [FLAG_W-1:0] mask_i,
    output logic [DATA_W-1:0] result_o,
    output logic [FLAG_W-1:0] flags_o
);
    localparam int DIGITS        = DATA_W / DIGIT_W;
    localparam int NARROW_DIGITS = NARROW_W / DIGIT_W;

    op_e               op;
    flags_t            flags_q, flags_d;
    logic [DATA_W-1:0] result_q, result_d;
    logic              sub, narrow, do_arith;

    logic [DATA_W-1:0] bin_sum, dec_sum, sel_sum, merged;
    logic              bin_c, bin_v, dec_c;
    logic              sel_c, sel_v, res_zero, res_neg;

    assign op       = op_e'(op_code_i);
    assign sub      = (op == OP_SBC);
    assign narrow   = flags_q.w;
    assign do_arith = op_valid_i && is_arith(op);

    bin_addsub #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) bin_i (
        .a_i          (opa_i),
        .b_i          (opb_i),
        .carry_flag_i (flags_q.c),
        .sub_i        (sub),
        .narrow_i     (narrow),
        .sum_o        (bin_sum),
        .carry_flag_o (bin_c),
        .ovf_o        (bin_v)
    );

    bcd_chain #(.DIGITS(DIGITS), .NARROW_DIGITS(NARROW_DIGITS)) dec_i (
        .a_i          (opa_i),
        .b_i          (opb_i),
        .carry_flag_i (flags_q.c),
        .sub_i        (sub),
        .narrow_i     (narrow),
        .sum_o        (dec_sum),
        .carry_flag_o (dec_c)
    );

    always_comb begin
        sel_sum = flags_q.d ? dec_sum : bin_sum;
        sel_c   = flags_q.d ? dec_c   : bin_c;
        sel_v   = flags_q.d ? 1'b0    : bin_v;
        if (narrow) begin
            merged   = {opa_i[DATA_W-1:NARROW_W], sel_sum[NARROW_W-1:0]};
            res_zero = (sel_sum[NARROW_W-1:0] == '0);
            res_neg  = sel_sum[NARROW_W-1];
        end else begin
            merged   = sel_sum;
            res_zero = (sel_sum == '0);
            res_neg  = sel_sum[DATA_W-1];
        end
        result_d = do_arith ? merged : result_q;
    end

    flag_unit flags_i (
        .valid_i (op_valid_i),
        .op_i    (op),
        .mask_i  (mask_i),
        .cur_i   (flags_q),
        .carry_i (sel_c),
        .zero_i  (res_zero),
        .neg_i   (res_neg),
        .ovf_i   (sel_v),
        .nxt_o   (flags_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            flags_q  <= '0;
        end else begin
            result_q <= result_d;
            flags_q  <= flags_d;
        end
    end

    assign result_o = result_q;
    assign flags_o  = flags_q;
endmodule

// File: rtl/bcd_alu_core_chk.sv
module bcd_alu_core_chk
    import alu_pkg::*;
#(
    parameter int DATA_W   = WORD_W,
    parameter int NARROW_W = BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid_i,
    input logic [2:0]        op_code_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [FLAG_W-1:0] mask_i,
    input logic [DATA_W-1:0] result_o,
    input logic [FLAG_W-1:0] flags_o
);
    logic arith_now;
    assign arith_now = op_valid_i &&
        ((op_code_i == OP_ADC) || (op_code_i == OP_SBC));

    assert_upper_pass_R5: assert property (@(posedge clk) disable iff (rst)
        (arith_now && flags_o[F_W]) |=>
            (result_o[DATA_W-1:NARROW_W] == $past(opa_i[DATA_W-1:NARROW_W])));

    assert_zero_narrow_R6: assert property (@(posedge clk) disable iff (rst)
        (arith_now && flags_o[F_W]) |=>
            (flags_o[F_Z] == (result_o[NARROW_W-1:0] == '0)));

    assert_zero_wide_R6: assert property (@(posedge clk) disable iff (rst)
        (arith_now && !flags_o[F_W]) |=>
            (flags_o[F_Z] == (result_o == '0)));

    assert_neg_narrow_R7: assert property (@(posedge clk) disable iff (rst)
        (arith_now && flags_o[F_W]) |=> (flags_o[F_N] == result_o[NARROW_W-1]));

    assert_neg_wide_R7: assert property (@(posedge clk) disable iff (rst)
        (arith_now && !flags_o[F_W]) |=> (flags_o[F_N] == result_o[DATA_W-1]));

    assert_dec_no_ovf_R8: assert property (@(posedge clk) disable iff (rst)
        (arith_now && flags_o[F_D]) |=> !flags_o[F_V]);

    assert_mask_set_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && op_code_i == OP_SETM) |=>
            (((flags_o & $past(mask_i)) == $past(mask_i)) && $stable(result_o)));

    assert_mask_clr_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && op_code_i == OP_CLRM) |=>
            (((flags_o & $past(mask_i)) == '0) && $stable(result_o)));

    assert_set_carry_R10: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && op_code_i == OP_SETC) |=>
            (flags_o[F_C] && flags_o[FLAG_W-1:1] == $past(flags_o[FLAG_W-1:1])));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!op_valid_i || op_code_i == OP_NONE) |=>
            ($stable(result_o) && $stable(flags_o)));
endmodule

bind bcd_alu_core bcd_alu_core_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .op_valid_i (op_valid_i),
    .op_code_i  (op_code_i),
    .opa_i      (opa_i),
    .mask_i     (mask_i),
    .result_o   (result_o),
    .flags_o    (flags_o)
);

// File: tb/bcd_alu_core_tb_top.sv
module bcd_alu_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid_i = 1'b0;
    logic [2:0]  op_code_i = 3'd0;
    logic [15:0] opa_i = '0;
    logic [15:0] opb_i = '0;
    logic [5:0]  mask_i = '0;
    logic [15:0] result_o;
    logic [5:0]  flags_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [5:0]  fl_m;     // model status: {w,d,n,v,z,c}
    logic [15:0] res_m;

    bcd_alu_core dut_i (
        .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
        .opa_i(opa_i), .opb_i(opb_i), .mask_i(mask_i),
        .result_o(result_o), .flags_o(flags_o)
    );

    always #10 clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int bcd2int(input logic [15:0] v, input int nd);
        int r = 0;
        for (int i = nd - 1; i >= 0; i--) r = r * 10 + int'(v[i*4 +: 4]);
        return r;
    endfunction

    function automatic logic [15:0] int2bcd(input int v, input int nd);
        logic [15:0] r = '0;
        int t = v;
        for (int i = 0; i < nd; i++) begin
            r[i*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic logic [15:0] rand_bcd();
        logic [15:0] r;
        for (int i = 0; i < 4; i++) r[i*4 +: 4] = 4'($urandom_range(9));
        return r;
    endfunction

    // Reference arithmetic: updates res_m and fl_m from the requirements.
    task automatic model_arith(input bit sub, input logic [15:0] a, input logic [15:0] b);
        int n    = fl_m[5] ? 8 : 16;
        int cin  = int'(fl_m[0]);
        int lim  = 1 << n;
        int am   = int'(a) % lim;
        int bm   = int'(b) % lim;
        int t, r, sa, sb, s;
        bit c, v;
        if (fl_m[4]) begin
            int nd  = n / 4;
            int mod = (nd == 2) ? 100 : 10000;
            int da  = bcd2int(a, nd);
            int db  = bcd2int(b, nd);
            t = sub ? (da - db - (1 - cin)) : (da + db + cin);
            if (sub) begin c = (t >= 0); if (t < 0) t = t + mod; end
            else     begin c = (t >= mod); if (t >= mod) t = t - mod; end
            r = int'(int2bcd(t, nd));
            v = 1'b0;
        end else begin
            t = sub ? (am - bm - (1 - cin)) : (am + bm + cin);
            c = sub ? (t >= 0) : (t >= lim);
            r = (t + lim) % lim;
            sa = (am >= lim / 2) ? am - lim : am;
            sb = (bm >= lim / 2) ? bm - lim : bm;
            s  = sub ? (sa - sb - (1 - cin)) : (sa + sb + cin);
            v  = (s >= lim / 2) || (s < -(lim / 2));
        end
        res_m = (n == 8) ? {a[15:8], 8'(r)} : 16'(r);
        fl_m[0] = c;
        fl_m[1] = (r == 0);
        fl_m[2] = v;
        fl_m[3] = (n == 8) ? res_m[7] : res_m[15];
    endtask

    task automatic apply(input bit valid, input logic [2:0] op,
                         input logic [15:0] a, input logic [15:0] b,
                         input logic [5:0] m);
        string tag;
        @(negedge clk);
        op_valid_i = valid; op_code_i = op; opa_i = a; opb_i = b; mask_i = m;
        if (!valid || op == 3'd0 || op == 3'd7) tag = "R11";
        else if (op == 3'd3 || op == 3'd4) tag = "R9";
        else if (op == 3'd5 || op == 3'd6) tag = "R10";
        else begin
            if (fl_m[4]) tag = (op == 3'd2) ? "R4" : "R3";
            else         tag = (op == 3'd2) ? "R2" : "R1";
            if (fl_m[5]) tag = {tag, " R5"};
        end
        if (valid) begin
            case (op)
                3'd1: model_arith(1'b0, a, b);
                3'd2: model_arith(1'b1, a, b);
                3'd3: fl_m = fl_m | m;
                3'd4: fl_m = fl_m & ~m;
                3'd5: fl_m[0] = 1'b1;
                3'd6: fl_m[0] = 1'b0;
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        op_valid_i = 1'b0;
        check(result_o == res_m, {tag, " result"}, result_o, res_m);
        check(flags_o == fl_m, {tag, " R6 R7 R8 flags"},
              {10'd0, flags_o}, {10'd0, fl_m});
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd4711);
        fl_m = '0; res_m = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        check(result_o == 16'h0000, "R12 reset result", result_o, 16'h0000);
        check(flags_o == 6'h00, "R12 reset flags", {10'd0, flags_o}, 16'h0000);

        // R1 binary add, wide
        apply(1, 3'd1, 16'h1234, 16'h4321, 6'h00);
        apply(1, 3'd5, 16'h0000, 16'h0000, 6'h00);          // R10
        apply(1, 3'd1, 16'hFFFF, 16'h0000, 6'h00);          // R1 carry, R6 zero
        apply(1, 3'd1, 16'h7FFF, 16'h0000, 6'h00);          // R8 overflow, R7
        apply(1, 3'd2, 16'h0000, 16'h0001, 6'h00);          // R2 borrow
        // R9: enter decimal mode, R10 clear carry
        apply(1, 3'd3, 16'hAAAA, 16'h5555, 6'h10);
        apply(1, 3'd6, 16'h0000, 16'h0000, 6'h00);
        apply(1, 3'd1, 16'h9999, 16'h0001, 6'h00);          // R3 -> 0000 carry
        apply(1, 3'd5, 16'h0000, 16'h0000, 6'h00);
        apply(1, 3'd2, 16'h0000, 16'h0001, 6'h00);          // R4 -> 9999 borrow
        // narrow decimal
        apply(1, 3'd3, 16'h0000, 16'h0000, 6'h20);
        apply(1, 3'd1, 16'h1299, 16'h3401, 6'h00);          // R3 R5 -> 1200
        apply(1, 3'd2, 16'h5600, 16'h0001, 6'h00);          // R4 R5 -> 5699
        // R11 idle and no-op code
        apply(0, 3'd1, 16'hFFFF, 16'hFFFF, 6'h3F);
        apply(1, 3'd0, 16'hFFFF, 16'hFFFF, 6'h3F);
        // narrow binary overflow
        apply(1, 3'd4, 16'h0000, 16'h0000, 6'h1F);
        apply(1, 3'd1, 16'hAB7F, 16'h0001, 6'h00);          // R1 R5 R8
        apply(1, 3'd4, 16'h0000, 16'h0000, 6'h3F);

        for (int i = 0; i < 800; i++) begin
            int unsigned sel = $urandom_range(11);
            logic [2:0]  op;
            logic [15:0] a, b;
            bit          valid = 1'b1;
            if (sel < 4)       op = 3'd1;
            else if (sel < 8)  op = 3'd2;
            else if (sel == 8) op = ($urandom_range(1) != 0) ? 3'd3 : 3'd4;
            else if (sel == 9) op = ($urandom_range(1) != 0) ? 3'd5 : 3'd6;
            else if (sel == 10) op = 3'd0;
            else begin op = 3'($urandom_range(7)); valid = 1'b0; end
            if (fl_m[4]) begin a = rand_bcd(); b = rand_bcd(); end
            else begin a = 16'($urandom); b = 16'($urandom); end
            if ($urandom_range(15) == 0) b = a;
            apply(valid, op, a, b, 6'($urandom));
        end
        summary();
        $finish;
    end
endmodule